// File: doc/BRIEF.md
# In-Order Read Return Buffer

This block sits between a memory back end that can finish reads in any order and a client read port with several lanes. Each read the client issues gets a sequence tag from a wrapping counter. The back end later hands back a completion that carries that tag and the read data. The buffer stores each completion in the slot the tag names. It then releases the stored data strictly in issue order.

Every cycle the buffer releases the oldest run of completed entries that has no gaps, up to one entry per lane. The oldest released entry goes on lane 0 and the others follow in order on the higher lanes. Each lane has its own valid bit. A completion whose tag is not waiting for data is dropped and flagged for one cycle. With the default package settings there are 8 slots, 4 lanes and 16-bit data. These are the settings that match a short-burst memory. Longer bursts would use fewer, wider lanes.

Top module: `inorder_rtn_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, rdReqReady is 1, rdReqTag is 0, cplError is 0 and every rdValid bit is 0.
- R2: Accepted reads receive tags 0, 1, 2 and so on in order, wrapping from 7 back to 0. rdReqTag shows the tag that the next accepted read will get.
- R3: At most 8 reads can be held, counting both reads still waiting for data and completed reads not yet released. While 8 are held, rdReqReady is 0. A request made while rdReqReady is 0 is not accepted and rdReqTag does not change.
- R4: Every read's data reaches the lanes exactly once, in issue order, whatever order the completions arrive in.
- R5: Up to 4 entries are released in a cycle. Lane i carries its data on rdData bits [16i+15:16i]. The oldest entry goes on lane 0 and later entries take higher lanes in order. The valid bits always form a run that starts at lane 0. Lanes outside the run have rdValid 0.
- R6: Take a completion accepted at clock edge k that leaves its entry at the head of a gap-free run. That entry is presented in the cycle after edge k+1, for that one cycle only.
- R7: A completion whose tag is not waiting for data is discarded. This covers a tag that was never issued and a tag that has already completed. After that edge, cplError is 1 for one cycle and the released data stream is unchanged.
- R8: Release stops at the oldest entry that has not completed. Completed entries behind it stay held and their lanes stay invalid.
- R9: Slots freed by a release can be reused at once. rdReqReady returns to 1 in the same cycle the released data appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReqValid | input | 1 | Client issues a read this cycle |
| rdReqReady | output | 1 | A free slot exists, so a read can be accepted |
| rdReqTag | output | 3 | Tag the next accepted read receives |
| cplValid | input | 1 | Back end delivers a completion |
| cplTag | input | 3 | Tag of the completion |
| cplData | input | 16 | Read data of the completion |
| cplError | output | 1 | The previous completion did not match a tag waiting for data |
| rdValid | output | 4 | Per-lane valid bits |
| rdData | output | 64 | Lane data, lane i in bits [16i+15:16i] |

## Verification
The timing follows the registers. A tag and the ready flag update one edge after a request. cplError rises one edge after a bad completion. Released data shows up two edges after the completion that closes the gap at the head, because one edge stores the data and the next edge drives the lane registers. The bench drives inputs and samples outputs on the falling clock edge, so each check reads the state left by the rising edges counted so far. It checks the exact lane pattern in the cycle each result is due, and also in the cycles just before and after. A lane monitor compares every valid lane against the issue-ordered list of expected data, and also checks that the valid bits start at lane 0 with no gaps.

// File: rtl/inorder_rtn_pkg.sv
package inorder_rtn_pkg;
  localparam int RTN_DEPTH = 8;
  localparam int RTN_CH    = 4;
  localparam int RTN_DW    = 16;
  localparam int TAG_W     = $clog2(RTN_DEPTH);
  localparam int CNT_W     = $clog2(RTN_DEPTH + 1);
  localparam int LANE_W    = $clog2(RTN_CH + 1);

  typedef logic [TAG_W-1:0] tag_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    tag_t              wrIdx;
    tag_t              headIdx;
    logic [LANE_W-1:0] relCount;
  } dp_strobe_t;
endpackage

// File: rtl/inorder_rtn_ctrl.sv
module inorder_rtn_ctrl
  import inorder_rtn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output tag_t       reqTag,
  input  logic       cplValid,
  input  tag_t       cplTag,
  output logic       cplError,
  output dp_strobe_t strobe
);
  tag_t                 headPtr;
  tag_t                 tailPtr;
  logic [CNT_W-1:0]     held;
  logic [RTN_DEPTH-1:0] allocBits;
  logic [RTN_DEPTH-1:0] doneBits;
  logic                 errQ;
  logic                 accept;
  logic                 cplOk;
  logic [LANE_W-1:0]    relCnt;

  assign reqReady = (held != CNT_W'(RTN_DEPTH));
  assign reqTag   = tailPtr;
  assign accept   = reqValid & reqReady;
  assign cplOk    = cplValid & allocBits[cplTag] & ~doneBits[cplTag];
  assign cplError = errQ;

  // Count the gap-free completed entries starting at the head
  always_comb begin
    logic stop;
    tag_t scanIdx;
    relCnt = '0;
    stop   = 1'b0;
    for (int i = 0; i < RTN_CH; i++) begin
      scanIdx = headPtr + TAG_W'(i);
      if (!stop && doneBits[scanIdx]) relCnt = relCnt + 1'b1;
      else stop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      held      <= '0;
      allocBits <= '0;
      doneBits  <= '0;
      errQ      <= 1'b0;
    end else begin
      if (accept) begin
        allocBits[tailPtr] <= 1'b1;
        doneBits[tailPtr]  <= 1'b0;
        tailPtr            <= tailPtr + 1'b1;
      end
      if (cplOk) doneBits[cplTag] <= 1'b1;
      for (int i = 0; i < RTN_CH; i++) begin
        if (LANE_W'(i) < relCnt) begin
          allocBits[headPtr + TAG_W'(i)] <= 1'b0;
          doneBits[headPtr + TAG_W'(i)]  <= 1'b0;
        end
      end
      headPtr <= headPtr + TAG_W'(relCnt);
      held    <= held + CNT_W'(accept) - CNT_W'(relCnt);
      errQ    <= cplValid & ~cplOk;
    end
  end

  always_comb begin
    strobe.wrEn     = cplOk;
    strobe.wrIdx    = cplTag;
    strobe.headIdx  = headPtr;
    strobe.relCount = relCnt;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    held <= CNT_W'(RTN_DEPTH));

  p_tag_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> $stable(tailPtr));

  p_release_alloc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (relCnt != '0) |-> allocBits[headPtr]);

  p_err_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    cplError |-> $past(cplValid));
endmodule

// File: rtl/inorder_rtn_dpath.sv
module inorder_rtn_dpath
  import inorder_rtn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_strobe_t               strobe,
  input  logic [RTN_DW-1:0]        cplData,
  output logic [RTN_CH-1:0]        outValid,
  output logic [RTN_CH*RTN_DW-1:0] outData
);
  logic [RTN_DW-1:0] store [RTN_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[strobe.wrIdx] <= cplData;
  end

  for (genvar ch = 0; ch < RTN_CH; ch++) begin : g_lane
    logic laneHit;
    assign laneHit = (LANE_W'(ch) < strobe.relCount);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid[ch]                  <= 1'b0;
        outData[ch*RTN_DW +: RTN_DW]  <= '0;
      end else begin
        outValid[ch]                  <= laneHit;
        outData[ch*RTN_DW +: RTN_DW]  <= laneHit ? store[strobe.headIdx + TAG_W'(ch)] : '0;
      end
    end
  end

  p_lanes_packed_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid + 1'b1) & outValid) == '0);
endmodule

// File: rtl/inorder_rtn_buf.sv
module inorder_rtn_buf
  import inorder_rtn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdReqValid,
  output logic                     rdReqReady,
  output logic [TAG_W-1:0]         rdReqTag,
  input  logic                     cplValid,
  input  logic [TAG_W-1:0]         cplTag,
  input  logic [RTN_DW-1:0]        cplData,
  output logic                     cplError,
  output logic [RTN_CH-1:0]        rdValid,
  output logic [RTN_CH*RTN_DW-1:0] rdData
);
  dp_strobe_t strobe;

  inorder_rtn_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (rdReqValid),
    .reqReady (rdReqReady),
    .reqTag   (rdReqTag),
    .cplValid (cplValid),
    .cplTag   (cplTag),
    .cplError (cplError),
    .strobe   (strobe)
  );

  inorder_rtn_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cplData  (cplData),
    .outValid (rdValid),
    .outData  (rdData)
  );
endmodule

// File: tb/tb_inorder_rtn_buf.sv
module tb_inorder_rtn_buf;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReqValid = 1'b0;
  logic        rdReqReady;
  logic [2:0]  rdReqTag;
  logic        cplValid = 1'b0;
  logic [2:0]  cplTag = '0;
  logic [15:0] cplData = '0;
  logic        cplError;
  logic [3:0]  rdValid;
  logic [63:0] rdData;

  always #2.5 clk = ~clk;

  inorder_rtn_buf dut (.*);

  int checks = 0;
  int fails = 0;
  int seed = 0;
  int expTag = 0;
  int wIdx = 0;
  int rIdx = 0;
  logic [15:0] expData [64];
  bit done = 0;

  // completion order for each table vector
  localparam logic [2:0] PERM [4][8] = '{
    '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
    '{3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    '{3'd1, 3'd0, 3'd3, 3'd2, 3'd5, 3'd4, 3'd7, 3'd6},
    '{3'd4, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3}
  };

  function automatic logic [15:0] mkData(int s, int t);
    return {s[7:0], 5'b0, t[2:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issueN(int n);
    for (int i = 0; i < n; i++) begin
      chk(rdReqReady == 1'b1, "R3", "ready before issue", rdReqReady, 1);
      chk(rdReqTag == 3'(expTag), "R2", "issued tag", rdReqTag, expTag);
      expData[wIdx] = mkData(seed, expTag);
      wIdx++;
      expTag = (expTag + 1) % 8;
      rdReqValid = 1'b1;
      step();
    end
    rdReqValid = 1'b0;
  endtask

  task automatic complete(int t, int s);
    cplValid = 1'b1;
    cplTag   = 3'(t);
    cplData  = mkData(s, t);
    step();
    cplValid = 1'b0;
  endtask

  // lane monitor: order R4, packing R5
  always @(negedge clk) begin
    if (rstN) begin
      for (int ch = 0; ch < 4; ch++) begin
        if (rdValid[ch]) begin
          if (ch > 0) chk(rdValid[ch-1], "R5", "lane gap", rdValid, 0);
          chk(rdData[ch*16 +: 16] == expData[rIdx], "R4", "lane data in order",
              rdData[ch*16 +: 16], expData[rIdx]);
          rIdx++;
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    chk(rdReqReady == 1'b1, "R1", "ready in reset", rdReqReady, 1);
    chk(rdReqTag == 3'd0, "R1", "tag in reset", rdReqTag, 0);
    chk(rdValid == 4'b0, "R1", "valid in reset", rdValid, 0);
    chk(cplError == 1'b0, "R1", "error in reset", cplError, 0);
    rstN = 1'b1;
    step();
    chk(rdValid == 4'b0 && cplError == 1'b0, "R1", "outputs after reset", rdValid, 0);

    // table of completion orders: R2 R3 R4 R9
    for (int v = 0; v < 4; v++) begin
      seed = v + 1;
      issueN(8);
      chk(rdReqReady == 1'b0, "R3", "full after 8", rdReqReady, 0);
      for (int i = 0; i < 8; i++) complete(int'(PERM[v][i]), seed);
      repeat (4) step();
      chk(rIdx == wIdx, "R4", "all released once", rIdx, wIdx);
      chk(rdReqReady == 1'b1, "R9", "ready after drain", rdReqReady, 1);
    end

    // R8 gap holds later entries, R6 timing
    seed = 200;
    issueN(4);
    complete(1, seed); complete(2, seed); complete(3, seed);
    for (int i = 0; i < 3; i++) begin
      chk(rdValid == 4'b0, "R8", "held behind gap", rdValid, 0);
      step();
    end
    complete(0, seed);
    chk(rdValid == 4'b0, "R6", "not yet after store edge", rdValid, 0);
    step();
    chk(rdValid == 4'b1111, "R6", "released one edge later", rdValid, 4'hf);
    step();
    chk(rdValid == 4'b0, "R6", "valid one cycle", rdValid, 0);

    // R5 partial lanes
    seed = 201;
    issueN(4);
    complete(5, seed);
    complete(4, seed);
    step();
    chk(rdValid == 4'b0011, "R5", "two lanes", rdValid, 4'h3);
    complete(7, seed);
    chk(rdValid == 4'b0, "R8", "7 held behind 6", rdValid, 0);
    complete(6, seed);
    step();
    chk(rdValid == 4'b0011, "R5", "two lanes again", rdValid, 4'h3);

    // R5 cap at four lanes, R3 rejected request, R9 reuse
    seed = 202;
    issueN(8);
    chk(rdReqReady == 1'b0, "R3", "full", rdReqReady, 0);
    rdReqValid = 1'b1;
    step();
    rdReqValid = 1'b0;
    chk(rdReqTag == 3'd0, "R3", "tag unchanged on reject", rdReqTag, 0);
    chk(rdReqReady == 1'b0, "R3", "still full", rdReqReady, 0);
    for (int t = 7; t >= 1; t--) complete(t, seed);
    complete(0, seed);
    chk(rdValid == 4'b0, "R6", "not yet", rdValid, 0);
    step();
    chk(rdValid == 4'b1111, "R5", "first four", rdValid, 4'hf);
    chk(rdReqReady == 1'b1, "R9", "ready with release", rdReqReady, 1);
    step();
    chk(rdValid == 4'b1111, "R5", "next four", rdValid, 4'hf);
    step();
    chk(rdValid == 4'b0, "R5", "drained", rdValid, 0);

    // R7 stray and duplicate completions
    seed = 203;
    complete(3, seed);
    chk(cplError == 1'b1, "R7", "stray tag flagged", cplError, 1);
    step();
    chk(cplError == 1'b0, "R7", "flag one cycle", cplError, 0);
    chk(rdValid == 4'b0, "R7", "stray discarded", rdValid, 0);
    issueN(1);
    complete(0, seed);
    chk(cplError == 1'b0, "R7", "good completion no flag", cplError, 0);
    complete(0, 250);
    chk(cplError == 1'b1, "R7", "duplicate flagged", cplError, 1);
    chk(rdValid == 4'b0001, "R7", "single release", rdValid, 4'h1);
    step();
    chk(rdValid == 4'b0 && cplError == 1'b0, "R7", "nothing extra", rdValid, 0);
    repeat (3) step();
    chk(rIdx == wIdx, "R4", "final stream count", rIdx, wIdx);

    done = 1;
    summary();
    $finish;
  end
endmodule